// File: doc/BRIEF.md
# Camera Register Configuration Sequencer

After reset, this block programs a camera sensor through its two-wire serial control bus. It steps through a small built-in list of settings. Each setting is a 16-bit register address paired with an 8-bit value, and each one goes out as a single write transaction. When the last setting has been written, the block raises a completion flag, and downstream pixel capture waits for that flag. The block never reads registers back. It is the only master on the bus and never issues a repeated start.

Both bus lines are open-drain. The block only pulls a line low or lets it go; the board pull-ups supply the high level. The block samples the data line in every acknowledge slot. If the sensor does not acknowledge a byte, the block sets a sticky error flag, ends the transaction with a stop, and retries the same setting once before moving on.

Top module: `cam_cfg_seq`

## Requirements
- R1: While reset is held, neither line is pulled low, and `cfg_done` and `nack_seen` are 0.
- R2: Every transaction sends four bytes, most significant bit first, in this order:
  - the device byte (`DEV_ADDR` shifted left by one, with bit 0 = 0 for a write);
  - the register address high byte;
  - the register address low byte;
  - the value byte.
- R3: Settings are written in index order 0 to `ENTRIES`-1. Setting i has address 16'h3100 + 259·i (modulo 2^16) and value 8'h5A XOR ((19·i) mod 256).
- R4: In every data and acknowledge slot of `BIT_CYCLES` clocks:
  - the clock line is low for the first quarter;
  - it is released for the middle half, a high pulse of exactly `BIT_CYCLES`/2 clocks;
  - it is low for the last quarter.
- R5: Outside start and stop conditions, the data line changes only while the clock line is low.
- R6: Each transaction opens with a start condition (data falls while clock is high) and closes with a stop condition (data rises while clock is high). Starts and stops strictly alternate.
- R7: The block releases the data line for the whole of every acknowledge slot. It samples the line at the middle of the clock-high phase, and a low level there is an acknowledge.
- R8: On a missing acknowledge:
  - `nack_seen` rises and stays high until reset;
  - no further bytes of that transaction are sent, and a stop follows that slot;
  - on the first failure of a setting, the whole transaction is repeated once.
- R9: If the repeated transaction also fails, the block moves on to the next setting without another attempt.
- R10: `cfg_done` rises exactly (total slots × `BIT_CYCLES`) clock edges after reset release. Each full transaction takes 38 slots, and a transaction cut short after byte k (0-based) takes 9·k + 11 slots. After that, `cfg_done` stays high, both lines stay released, and no further traffic appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_in | input | 1 | Sensed level of the data line |
| scl_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_low | output | 1 | 1 pulls the data line low, 0 releases it |
| cfg_done | output | 1 | All settings written, capture may start |
| nack_seen | output | 1 | Sticky flag: an acknowledge was missed |

## Verification
A wrong slot state, bit counter or byte index shows up at the bus within one bit period. It appears as a misplaced start or stop, a clock pulse of the wrong width, or a wrong byte that the bench's bus listener decodes. A wrong setting index or retry decision shows up as a wrong sequence of decoded transactions. It also moves the cycle on which `cfg_done` rises, which the bench predicts exactly from the slot count of each attempt. The acknowledge paths are covered by a listener that refuses chosen bytes of chosen transactions: a refused device byte, a refused middle byte, and a setting refused twice in a row.

// File: rtl/cam_cfg_pkg.sv
package cam_cfg_pkg;

  typedef enum logic [2:0] {
    SL_START,
    SL_BIT,
    SL_ACK,
    SL_STOP,
    SL_DONE
  } slot_e;

  // settings list, computed rather than stored
  function automatic logic [15:0] reg_addr_of(input int unsigned idx);
    return 16'(32'h3100 + idx * 32'd259);
  endfunction

  function automatic logic [7:0] reg_val_of(input int unsigned idx);
    return 8'h5A ^ 8'((idx * 32'd19) & 32'hFF);
  endfunction

  // byte k of a write frame
  function automatic logic [7:0] frame_byte(input logic [6:0] dev,
                                            input logic [15:0] addr,
                                            input logic [7:0] val,
                                            input logic [1:0] k);
    case (k)
      2'd0:    return {dev, 1'b0};
      2'd1:    return addr[15:8];
      2'd2:    return addr[7:0];
      default: return val;
    endcase
  endfunction

  // clock line released (high) for this slot and phase count
  function automatic logic scl_released(input slot_e s, input int c, input int q);
    case (s)
      SL_START:       return c < 3 * q;
      SL_BIT, SL_ACK: return (c >= q) && (c < 3 * q);
      SL_STOP:        return c >= q;
      default:        return 1'b1;
    endcase
  endfunction

  // data line pulled low for this slot and phase count
  function automatic logic sda_pull(input slot_e s, input int c, input int q,
                                    input logic bitv);
    case (s)
      SL_START: return c >= 2 * q;
      SL_BIT:   return !bitv;
      SL_STOP:  return c < 2 * q;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cam_cfg_slot_timer.sv
module cam_cfg_slot_timer #(
  parameter int BIT_CYCLES = 500,
  localparam int CW = $clog2(BIT_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          slot_end,
  output logic          slot_mid
);
  localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] MID  = CW'(BIT_CYCLES / 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (slot_end) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign slot_end = (cnt == LAST);
  assign slot_mid = (cnt == MID);
endmodule

// File: rtl/cam_cfg_table.sv
module cam_cfg_table
  import cam_cfg_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [IW-1:0] idx,
  output logic [15:0]   addr,
  output logic [7:0]    val
);
  logic [15:0] addr_tbl [ENTRIES];
  logic [7:0]  val_tbl  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    assign addr_tbl[g] = reg_addr_of(g);
    assign val_tbl[g]  = reg_val_of(g);
  end

  assign addr = addr_tbl[idx];
  assign val  = val_tbl[idx];
endmodule

// File: rtl/cam_cfg_seq.sv
module cam_cfg_seq
  import cam_cfg_pkg::*;
#(
  parameter int         BIT_CYCLES = 500,
  parameter int         ENTRIES    = 4,
  parameter logic [6:0] DEV_ADDR   = 7'h3C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_in,
  output logic scl_low,
  output logic sda_low,
  output logic cfg_done,
  output logic nack_seen
);
  localparam int CW = $clog2(BIT_CYCLES);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int Q  = BIT_CYCLES / 4;
  localparam logic [IW-1:0] LAST_IDX = IW'(ENTRIES - 1);

  slot_e         slot;
  logic [CW-1:0] cnt;
  logic          slot_end, slot_mid;
  logic [2:0]    bit_idx;
  logic [1:0]    byte_idx;
  logic [IW-1:0] entry;
  logic          retried, txn_fail, ack_hi;
  logic [15:0]   cur_addr;
  logic [7:0]    cur_val, cur_byte;

  // named events for the checker
  logic in_ack, in_edge_slot, nack_evt;
  assign in_ack       = (slot == SL_ACK);
  assign in_edge_slot = (slot == SL_START) || (slot == SL_STOP);
  assign nack_evt     = in_ack && slot_end && ack_hi;

  cam_cfg_slot_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .slot_end(slot_end), .slot_mid(slot_mid)
  );

  cam_cfg_table #(.ENTRIES(ENTRIES)) u_table (
    .idx(entry), .addr(cur_addr), .val(cur_val)
  );

  assign cur_byte = frame_byte(DEV_ADDR, cur_addr, cur_val, byte_idx);

  always_comb begin
    scl_low = !scl_released(slot, int'(cnt), Q);
    sda_low = sda_pull(slot, int'(cnt), Q, cur_byte[bit_idx]);
  end

  assign cfg_done = (slot == SL_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot      <= SL_START;
      bit_idx   <= 3'd7;
      byte_idx  <= 2'd0;
      entry     <= '0;
      retried   <= 1'b0;
      txn_fail  <= 1'b0;
      ack_hi    <= 1'b0;
      nack_seen <= 1'b0;
    end else begin
      if (in_ack && slot_mid) ack_hi <= sda_in;
      if (slot_end) begin
        unique case (slot)
          SL_START: begin
            slot     <= SL_BIT;
            bit_idx  <= 3'd7;
            byte_idx <= 2'd0;
          end
          SL_BIT: begin
            if (bit_idx == 3'd0) slot <= SL_ACK;
            else                 bit_idx <= bit_idx - 3'd1;
          end
          SL_ACK: begin
            if (ack_hi) begin
              nack_seen <= 1'b1;
              txn_fail  <= 1'b1;
              slot      <= SL_STOP;
            end else if (byte_idx == 2'd3) begin
              slot <= SL_STOP;
            end else begin
              byte_idx <= byte_idx + 2'd1;
              bit_idx  <= 3'd7;
              slot     <= SL_BIT;
            end
          end
          SL_STOP: begin
            txn_fail <= 1'b0;
            if (txn_fail && !retried) begin
              retried <= 1'b1;
              slot    <= SL_START;
            end else if (entry == LAST_IDX) begin
              slot <= SL_DONE;
            end else begin
              entry   <= entry + 1'b1;
              retried <= 1'b0;
              slot    <= SL_START;
            end
          end
          default: slot <= SL_DONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cam_cfg_checker.sv
module cam_cfg_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_low,
  input logic sda_low,
  input logic cfg_done,
  input logic nack_seen,
  input logic in_ack,
  input logic in_edge_slot,
  input logic nack_evt
);
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done); // R10

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> (!scl_low && !sda_low)); // R10

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    nack_seen |=> nack_seen); // R8

  AST_NACK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> nack_seen); // R8

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |-> !sda_low); // R7

  AST_SDA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_edge_slot && !scl_low && $past(!scl_low)) |-> $stable(sda_low)); // R5
endmodule

bind cam_cfg_seq cam_cfg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_low(scl_low), .sda_low(sda_low),
  .cfg_done(cfg_done), .nack_seen(nack_seen), .in_ack(in_ack),
  .in_edge_slot(in_edge_slot), .nack_evt(nack_evt)
);

// File: tb/cam_cfg_seq_test.sv
module cam_cfg_seq_test;
  localparam int N = 8;
  localparam int E = 4;
  localparam int MAXT = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic slave_low = 1'b0;
  logic scl_low, sda_low, cfg_done, nack_seen;
  wire  sda_line = !(sda_low || slave_low);
  wire  scl_line = !scl_low;

  cam_cfg_seq #(.BIT_CYCLES(N), .ENTRIES(E), .DEV_ADDR(7'h3C)) uut (
    .clk(clk), .rst_n(rst_n), .sda_in(sda_line), .scl_low(scl_low),
    .sda_low(sda_low), .cfg_done(cfg_done), .nack_seen(nack_seen)
  );

  int tests = 0, fails = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bus listener state
  int nackb [MAXT];
  logic [7:0] rec [MAXT][4];
  int rec_n [MAXT];
  int txn, bitcnt, byte_k, hi_w, cyc;
  logic [7:0] sh;
  logic p_scl, p_sda, in_txn, pulse_edge;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      txn = 0; bitcnt = 0; byte_k = 0; hi_w = 0; sh = 8'h00;
      p_scl = 1'b1; p_sda = 1'b1; in_txn = 1'b0; pulse_edge = 1'b0;
      slave_low = 1'b0;
    end else begin
      if (scl_line && p_scl && p_sda && !sda_line) begin
        check(!in_txn, "R6 start inside transaction", 1, 0);
        in_txn = 1'b1; bitcnt = 0; byte_k = 0; pulse_edge = 1'b1;
      end
      if (scl_line && p_scl && !p_sda && sda_line) begin
        check(in_txn, "R6 stop without start", 0, 1);
        if (txn < MAXT) rec_n[txn] = byte_k;
        txn++; in_txn = 1'b0; pulse_edge = 1'b1;
      end
      if (scl_line) hi_w++;
      if (scl_line && !p_scl && bitcnt < 8) begin
        sh = {sh[6:0], sda_line};
        bitcnt++;
      end
      if (!scl_line && p_scl) begin
        if (!pulse_edge) check(hi_w == N / 2, "R4 clock high width", hi_w, N / 2);
        hi_w = 0; pulse_edge = 1'b0;
        if (bitcnt == 8) begin
          if (txn < MAXT && byte_k < 4) rec[txn][byte_k] = sh;
          slave_low = (txn >= MAXT) || (nackb[txn] != byte_k);
          byte_k++;
          bitcnt = 9;
        end else if (bitcnt == 9) begin
          slave_low = 1'b0;
          bitcnt = 0;
        end
      end
      p_scl = scl_line;
      p_sda = sda_line;
    end
  end

  function automatic logic [7:0] exp_byte(input int e, input int k);
    int a = (12544 + 259 * e) % 65536;
    int v = 90 ^ ((19 * e) % 256);
    case (k)
      0: return 8'h78;
      1: return 8'(a / 256);
      2: return 8'(a % 256);
      default: return 8'(v);
    endcase
  endfunction

  task automatic run_case(input string name, input int n0, input int n1,
                          input int n2, input int n3, input int n4);
    int t, total, waited, nb, need;
    bit any_nack;
    for (int i = 0; i < MAXT; i++) begin nackb[i] = -1; rec_n[i] = -1; end
    nackb[0] = n0; nackb[1] = n1; nackb[2] = n2; nackb[3] = n3; nackb[4] = n4;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!scl_low && !sda_low, {"R1 lines released in reset ", name},
          int'({scl_low, sda_low}), 0);
    check(!cfg_done && !nack_seen, {"R1 flags clear in reset ", name},
          int'({cfg_done, nack_seen}), 0);
    rst_n = 1'b1;
    waited = 0;
    while (!cfg_done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    check(cfg_done, {"R10 watchdog, done never rose ", name}, 0, 1);
    // expected attempts
    t = 0; total = 0; any_nack = 0;
    for (int e = 0; e < E; e++) begin
      for (int a = 0; a < 2; a++) begin
        nb = nackb[t];
        need = (nb < 0) ? 4 : nb + 1;
        check(rec_n[t] == need, {"R8 bytes in attempt ", name}, rec_n[t], need);
        for (int k = 0; k < need; k++)
          check(rec[t][k] == exp_byte(e, k), {"R2 R3 frame byte ", name},
                int'(rec[t][k]), int'(exp_byte(e, k)));
        total += (nb < 0) ? 38 : 9 * nb + 11;
        t++;
        if (nb >= 0) any_nack = 1;
        if (nb < 0) break;
      end
    end
    check(txn == t, {"R9 transaction count ", name}, txn, t);
    check(cyc == total * N, {"R10 done cycle ", name}, cyc, total * N);
    check(nack_seen == any_nack, {"R8 sticky error ", name}, int'(nack_seen), int'(any_nack));
    repeat (3 * N) @(negedge clk);
    check(cfg_done && !scl_low && !sda_low, {"R10 quiet after done ", name},
          int'({cfg_done, scl_low, sda_low}), 4);
    check(txn == t, {"R10 no traffic after done ", name}, txn, t);
  endtask

  initial begin
    run_case("all ack", -1, -1, -1, -1, -1);
    run_case("retry ok", -1, 2, -1, -1, -1);
    run_case("double fail", -1, -1, 0, 0, -1);
    run_case("first device refused", 0, -1, 3, -1, -1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule